// File: doc/BRIEF.md
# Seconds Counter with Alarm and Tick Interrupts

This peripheral keeps time as a plain count of seconds. A clock enable pulsing at the oscillator rate (nominally 32.768 kHz) feeds a prescaler whose period is set by a divider field. An optional trim field shortens one prescaler period in every group of 1024. Each prescaler wrap is a one-second tick that advances a 32-bit counter. A 32-bit alarm value is compared against the counter as it advances.

Two pending flags record "alarm reached" and "a tick happened". Each flag has its own enable bit, and each flag/enable pair drives its own interrupt line. Software reaches all state through a small register bus with a single write strobe, a byte address and a combinational read-data path. The bus and the oscillator enable share one clock.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the counter and the alarm read 0, the prescaler register reads 0x00007FFF (divider 32767, trim 0), the status register reads 0, and both interrupt outputs are low.
- R2: The register is selected by address bits [3:2]: 0 alarm, 1 counter, 2 prescaler, 3 status. Address bits [1:0] are ignored. A non-zero address bit above bit 3 selects no register: reads return 0 and writes change nothing.
- R3: With trim 0, a tick occurs once every divider+1 oscillator enables. Clock cycles without an oscillator enable do not advance the prescaler.
- R4: The first prescaler period after reset, and every 1024th period after it, is shortened by trim oscillator enables. A trim equal to or larger than the divider makes that period one oscillator enable long.
- R5: Each tick adds one to the counter, and the counter wraps from 0xFFFFFFFF to 0.
- R6: A bus write to the counter loads the written value. When a write and a tick fall in the same cycle, the write wins.
- R7: The alarm pending flag (status bit 0) is set on the clock edge where a tick advances the counter to the alarm value. Bus writes to the counter or to the alarm never set it.
- R8: Every tick sets the tick pending flag (status bit 1).
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R10: Status bits 2 (alarm enable) and 3 (tick enable) take the written value on every status write.
- R11: Each interrupt output is high exactly when its pending flag and its enable are both set. Pending flags latch while their enable is clear.
- R12: The prescaler register holds the divider in bits [15:0] and the 10-bit trim in bits [25:16]. Bits [31:26] read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and oscillator-sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_second | output | 1 | Tick interrupt |

## Verification
The hardest behaviour to reach from the ports is the trim correction, because it affects only one period in 1024 and its phase is hidden. The stimulus programs a short divider, drives the oscillator enable every cycle, aligns to a counter change and sums the lengths of 1024 consecutive periods. That sum is fixed whatever the phase, so the shortening shows up as an exact deficit. A divider of zero makes a tick happen on every oscillator enable, which forces set/clear collisions on the pending flags. A random phase with small alarm and counter values produces many alarm hits that coincide with counter and alarm writes.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

   typedef enum logic [1:0] {
      SEL_ALARM   = 2'd0,
      SEL_COUNT   = 2'd1,
      SEL_TRIMDIV = 2'd2,
      SEL_STATUS  = 2'd3
   } reg_sel_e;

   localparam int unsigned NUM_FLAGS    = 2;
   localparam int unsigned FLAG_ALARM   = 0;
   localparam int unsigned FLAG_SECOND  = 1;
   // enables sit this many bits above their pending flags
   localparam int unsigned ENABLE_SHIFT = 2;

endpackage

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler #(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned TRIM_W      = 10,
   parameter int unsigned TRIM_PERIOD = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic [DIV_W-1:0]  divider,
   input  logic [TRIM_W-1:0] trim,
   output logic              tick
);
   localparam int unsigned GRP_W    = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;
   localparam bit          GRP_POW2 = (TRIM_PERIOD == (1 << GRP_W));

   generate
      if (TRIM_PERIOD < 2) begin : g_bad_period
         $error("rtcal_prescaler: TRIM_PERIOD must be at least 2");
      end
      if (TRIM_W > DIV_W) begin : g_bad_trim
         $error("rtcal_prescaler: TRIM_W must not exceed DIV_W");
      end
   endgenerate

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] trim_ext;
   logic [DIV_W-1:0] short_lim;
   logic [DIV_W-1:0] limit;
   logic [GRP_W-1:0] grp_q;
   logic [GRP_W-1:0] grp_next;
   logic             grp_first;

   assign trim_ext  = DIV_W'(trim);
   // saturate: an oversized trim leaves a single-enable period
   assign short_lim = (trim_ext >= divider) ? '0 : (divider - trim_ext);
   assign grp_first = (grp_q == '0);
   assign limit     = grp_first ? short_lim : divider;
   assign tick      = osc_tick && (phase_q >= limit);

   generate
      if (GRP_POW2) begin : g_grp_wrap
         assign grp_next = grp_q + 1'b1;
      end else begin : g_grp_mod
         assign grp_next = (grp_q == GRP_W'(TRIM_PERIOD - 1)) ? '0 : (grp_q + 1'b1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         grp_q   <= '0;
      end else if (osc_tick) begin
         if (tick) begin
            phase_q <= '0;
            grp_q   <= grp_next;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rtcal_seconds.sv
module rtcal_seconds #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] alarm_val,
   output logic [CNT_W-1:0] count,
   output logic             alarm_hit
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] next_up;

   assign next_up   = count_q + 1'b1;
   // match is taken against the value the counter is about to hold
   assign alarm_hit = tick && !load && (next_up == alarm_val);
   assign count     = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (tick) begin
         count_q <= next_up;
      end
   end

endmodule

// File: rtl/rtcal_status.sv
module rtcal_status #(
   parameter int unsigned NUM_FLAGS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [NUM_FLAGS-1:0] clr_mask,
   input  logic [NUM_FLAGS-1:0] en_val,
   input  logic [NUM_FLAGS-1:0] set_ev,
   output logic [NUM_FLAGS-1:0] pend,
   output logic [NUM_FLAGS-1:0] en,
   output logic [NUM_FLAGS-1:0] irq
);
   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         logic pend_q;
         logic en_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               en_q   <= 1'b0;
            end else begin
               // a new event outranks a clearing write
               pend_q <= set_ev[g] | (pend_q & ~(wr & clr_mask[g]));
               if (wr) begin
                  en_q <= en_val[g];
               end
            end
         end

         assign pend[g] = pend_q;
         assign en[g]   = en_q;
         assign irq[g]  = pend_q & en_q;
      end
   endgenerate

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
   import rtcal_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned TRIM_W      = 10,
   parameter int unsigned TRIM_PERIOD = 1024,
   parameter int unsigned RESET_DIV   = 32767
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_alarm,
   output logic              irq_second
);
   localparam int unsigned TRIM_LSB = DIV_W;
   localparam int unsigned STAT_W   = NUM_FLAGS + ENABLE_SHIFT;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("rtc_sec_alarm: ADDR_W must be at least 4");
      end
      if (DIV_W + TRIM_W > BUS_W) begin : g_bad_pack
         $error("rtc_sec_alarm: divider and trim do not fit the bus");
      end
      if (CNT_W > BUS_W) begin : g_bad_cnt
         $error("rtc_sec_alarm: CNT_W exceeds BUS_W");
      end
      if (RESET_DIV >= (1 << DIV_W)) begin : g_bad_rdiv
         $error("rtc_sec_alarm: RESET_DIV does not fit DIV_W");
      end
      if (STAT_W > BUS_W) begin : g_bad_stat
         $error("rtc_sec_alarm: status field exceeds BUS_W");
      end
   endgenerate

   // address decode
   logic     in_map;
   reg_sel_e sel;
   logic     unused_addr;

   generate
      if (ADDR_W > 4) begin : g_hi_addr
         assign in_map = (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_no_hi_addr
         assign in_map = 1'b1;
      end
   endgenerate

   assign sel         = reg_sel_e'(bus_addr[3:2]);
   assign unused_addr = ^bus_addr[1:0];

   logic wr_alarm, cnt_load, wr_trimdiv, st_wr;
   assign wr_alarm   = bus_wr && in_map && (sel == SEL_ALARM);
   assign cnt_load   = bus_wr && in_map && (sel == SEL_COUNT);
   assign wr_trimdiv = bus_wr && in_map && (sel == SEL_TRIMDIV);
   assign st_wr      = bus_wr && in_map && (sel == SEL_STATUS);

   // configuration registers
   logic [CNT_W-1:0]  alarm_q;
   logic [DIV_W-1:0]  div_q;
   logic [TRIM_W-1:0] trim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         div_q   <= DIV_W'(RESET_DIV);
         trim_q  <= '0;
      end else begin
         if (wr_alarm) begin
            alarm_q <= bus_wdata[CNT_W-1:0];
         end
         if (wr_trimdiv) begin
            div_q  <= bus_wdata[DIV_W-1:0];
            trim_q <= bus_wdata[TRIM_LSB +: TRIM_W];
         end
      end
   end

   // prescaler
   logic sec_tick;

   rtcal_prescaler #(
      .DIV_W       (DIV_W),
      .TRIM_W      (TRIM_W),
      .TRIM_PERIOD (TRIM_PERIOD)
   ) u_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .divider  (div_q),
      .trim     (trim_q),
      .tick     (sec_tick)
   );

   // seconds counter and alarm compare
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_wval;
   logic             alarm_hit;

   assign cnt_wval = bus_wdata[CNT_W-1:0];

   rtcal_seconds #(
      .CNT_W (CNT_W)
   ) u_seconds (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .load      (cnt_load),
      .load_val  (cnt_wval),
      .alarm_val (alarm_q),
      .count     (cnt_q),
      .alarm_hit (alarm_hit)
   );

   // pending flags, enables, interrupts
   logic [NUM_FLAGS-1:0] set_ev;
   logic [NUM_FLAGS-1:0] pend_q;
   logic [NUM_FLAGS-1:0] en_q;
   logic [NUM_FLAGS-1:0] irq_vec;
   logic [NUM_FLAGS-1:0] st_clr;
   logic [NUM_FLAGS-1:0] st_en_val;

   always_comb begin
      set_ev              = '0;
      set_ev[FLAG_ALARM]  = alarm_hit;
      set_ev[FLAG_SECOND] = sec_tick;
   end

   assign st_clr    = bus_wdata[NUM_FLAGS-1:0];
   assign st_en_val = bus_wdata[ENABLE_SHIFT +: NUM_FLAGS];

   rtcal_status #(
      .NUM_FLAGS (NUM_FLAGS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (st_wr),
      .clr_mask (st_clr),
      .en_val   (st_en_val),
      .set_ev   (set_ev),
      .pend     (pend_q),
      .en       (en_q),
      .irq      (irq_vec)
   );

   assign irq_alarm  = irq_vec[FLAG_ALARM];
   assign irq_second = irq_vec[FLAG_SECOND];

   // read path
   always_comb begin
      bus_rdata = '0;
      if (in_map) begin
         case (sel)
            SEL_ALARM:   bus_rdata = BUS_W'(alarm_q);
            SEL_COUNT:   bus_rdata = BUS_W'(cnt_q);
            SEL_TRIMDIV: bus_rdata = BUS_W'({trim_q, div_q});
            SEL_STATUS:  bus_rdata = BUS_W'({en_q, pend_q});
            default:     bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/rtcal_checker.sv
module rtcal_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_tick,
   input logic             sec_tick,
   input logic             cnt_load,
   input logic [CNT_W-1:0] cnt_wval,
   input logic [CNT_W-1:0] cnt_q,
   input logic [1:0]       pend_q,
   input logic [1:0]       en_q,
   input logic             st_wr,
   input logic [1:0]       st_en_val,
   input logic             irq_alarm,
   input logic             irq_second
);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cnt_q == '0) && (pend_q == 2'b00) && !irq_alarm && !irq_second);

   p_tick_needs_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> osc_tick);

   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !cnt_load) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !cnt_load) |=> $stable(cnt_q));

   p_count_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> (cnt_q == $past(cnt_wval)));

   p_alarm_from_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[0]) |-> ($past(sec_tick) && !$past(cnt_load)));

   p_tick_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> pend_q[1]);

   p_enable_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |=> (en_q == $past(st_en_val)));

   p_irq_alarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_alarm |-> (pend_q[0] && en_q[0]));

   p_irq_second_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_second |-> (pend_q[1] && en_q[1]));

endmodule

bind rtc_sec_alarm rtcal_checker #(
   .CNT_W (CNT_W)
) u_rtcal_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .osc_tick   (osc_tick),
   .sec_tick   (sec_tick),
   .cnt_load   (cnt_load),
   .cnt_wval   (cnt_wval),
   .cnt_q      (cnt_q),
   .pend_q     (pend_q),
   .en_q       (en_q),
   .st_wr      (st_wr),
   .st_en_val  (st_en_val),
   .irq_alarm  (irq_alarm),
   .irq_second (irq_second)
);

// File: tb/rtc_sec_alarm_bench.sv
module rtc_sec_alarm_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_alarm;
   logic        irq_second;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   // oscillator enable generator
   bit osc_on = 1'b0;
   bit osc_rnd = 1'b0;
   int osc_gap = 1;
   int gap_cnt = 0;

   always #10 clk = ~clk;

   rtc_sec_alarm u_rtc_sec_alarm (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick   (osc_tick),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_alarm  (irq_alarm),
      .irq_second (irq_second)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_alarm, m_cnt;
   logic [15:0] m_div;
   logic [9:0]  m_trim;
   int          m_pcnt, m_tcnt;
   logic [1:0]  m_pend, m_en;
   int          m_lim;
   bit          m_tk, m_hit, m_wcnt, m_map;
   logic [1:0]  m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_alarm = 0; m_cnt = 0; m_div = 16'd32767; m_trim = 0;
         m_pcnt = 0; m_tcnt = 0; m_pend = 0; m_en = 0;
      end else begin
         m_tk = 0;
         if (osc_tick) begin
            if (m_tcnt == 0)
               m_lim = (int'(m_trim) >= int'(m_div)) ? 0 : int'(m_div) - int'(m_trim);
            else
               m_lim = int'(m_div);
            if (m_pcnt >= m_lim) begin
               m_tk = 1; m_pcnt = 0; m_tcnt = (m_tcnt + 1) % 1024;
            end else begin
               m_pcnt++;
            end
         end
         m_map  = (bus_addr[5:4] == 2'b00);
         m_wcnt = bus_wr && m_map && (bus_addr[3:2] == 2'd1);
         m_hit  = m_tk && !m_wcnt && ((m_cnt + 32'd1) == m_alarm);
         m_clr  = 2'b00;
         if (bus_wr && m_map && bus_addr[3:2] == 2'd3) begin
            m_clr = bus_wdata[1:0];
            m_en  = bus_wdata[3:2];
         end
         m_pend = (m_pend & ~m_clr) | {m_tk, m_hit};
         if (m_wcnt) m_cnt = bus_wdata;
         else if (m_tk) m_cnt = m_cnt + 32'd1;
         if (bus_wr && m_map && bus_addr[3:2] == 2'd0) m_alarm = bus_wdata;
         if (bus_wr && m_map && bus_addr[3:2] == 2'd2) begin
            m_div  = bus_wdata[15:0];
            m_trim = bus_wdata[25:16];
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      if (a[5:4] != 2'b00) return 32'h0;
      case (a[3:2])
         2'd0: return m_alarm;
         2'd1: return m_cnt;
         2'd2: return {6'h0, m_trim, m_div};
         default: return {28'h0, m_en, m_pend};
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] a);
      if (a[5:4] != 2'b00) return "R2";
      case (a[3:2])
         2'd0: return "R7";
         2'd1: return "R5";
         2'd2: return "R12";
         default: return "R9";
      endcase
   endfunction

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n && cmp_on) begin
         chk(bus_rdata == exp_rd(bus_addr), tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
         chk(irq_alarm == (m_pend[0] & m_en[0]), "R11 irq_alarm", {31'h0, irq_alarm}, {31'h0, m_pend[0] & m_en[0]});
         chk(irq_second == (m_pend[1] & m_en[1]), "R11 irq_second", {31'h0, irq_second}, {31'h0, m_pend[1] & m_en[1]});
      end
   end

   always @(negedge clk) begin
      #1;
      if (!osc_on) begin
         osc_tick = 1'b0;
      end else if (osc_rnd) begin
         osc_tick = ($urandom % 2) == 0;
      end else begin
         gap_cnt  = (gap_cnt + 1) % osc_gap;
         osc_tick = (gap_cnt == 0);
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic check_reset_state();
      logic [31:0] v;
      rd(6'h00, v); chk(v == 32'h0, "R1 alarm", v, 32'h0);
      rd(6'h04, v); chk(v == 32'h0, "R1 counter", v, 32'h0);
      rd(6'h08, v); chk(v == 32'h0000_7FFF, "R1 prescaler", v, 32'h0000_7FFF);
      rd(6'h0C, v); chk(v == 32'h0, "R1 status", v, 32'h0);
      chk(!irq_alarm && !irq_second, "R1 irqs", {30'h0, irq_second, irq_alarm}, 32'h0);
   endtask

   // sum of n consecutive tick intervals, in clock cycles
   task automatic measure(input int n, output int total);
      logic [31:0] prev;
      int k;
      @(negedge clk); #1 bus_addr = 6'h04;
      @(negedge clk); prev = bus_rdata;
      while (bus_rdata == prev) @(negedge clk);
      prev = bus_rdata;
      total = 0; k = 0;
      while (k < n) begin
         @(negedge clk);
         total++;
         if (bus_rdata != prev) begin
            k++;
            prev = bus_rdata;
         end
      end
   endtask

   task automatic next_count(output logic [31:0] nv);
      logic [31:0] prev;
      @(negedge clk); #1 bus_addr = 6'h04;
      @(negedge clk); prev = bus_rdata;
      while (bus_rdata == prev) @(negedge clk);
      nv = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      int t;
      bit seen;

      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      check_reset_state();

      // R12: field layout of the prescaler register
      wr(6'h08, 32'hFFFF_FFFF);
      rd(6'h08, v); chk(v == 32'h03FF_FFFF, "R12 field mask", v, 32'h03FF_FFFF);
      wr(6'h08, 32'h0000_0004);

      // R3: period of divider+1 enables, enables every cycle and every other cycle
      osc_gap = 1; osc_on = 1'b1;
      measure(3, t); chk(t == 15, "R3 period gap1", t, 15);
      osc_gap = 2;
      measure(2, t); chk(t == 20, "R3 period gap2", t, 20);
      osc_gap = 1; osc_on = 1'b0;
      repeat (3) @(negedge clk);

      // R6 load, R5 wrap
      wr(6'h04, 32'hFFFF_FFFF);
      rd(6'h04, v); chk(v == 32'hFFFF_FFFF, "R6 load", v, 32'hFFFF_FFFF);
      osc_on = 1'b1;
      next_count(v); chk(v == 32'h0, "R5 wrap", v, 32'h0);
      osc_on = 1'b0;
      repeat (3) @(negedge clk);

      // R7: alarm from tick only
      wr(6'h0C, 32'h3);
      wr(6'h0C, 32'h4);
      wr(6'h00, 32'd3);
      wr(6'h04, 32'd3);
      rd(6'h0C, v); chk(v[0] == 1'b0, "R7 write no alarm", v, 32'h4);
      wr(6'h04, 32'd1);
      osc_on = 1'b1;
      seen = 1'b0;
      while (!seen) begin
         next_count(v);
         if (v == 32'd2) chk(!irq_alarm, "R7 early", {31'h0, irq_alarm}, 32'h0);
         if (v == 32'd3) begin
            chk(irq_alarm, "R7 hit same edge", {31'h0, irq_alarm}, 32'h1);
            seen = 1'b1;
         end
      end

      // R9 clear only the written ones; R11 latch without enable
      wr(6'h0C, 32'h1);
      rd(6'h0C, v); chk(v == 32'h2, "R9 w1c", v, 32'h2);
      chk(!irq_second, "R11 latched no irq", {31'h0, irq_second}, 32'h0);
      // R10 enables take written value
      wr(6'h0C, 32'h8);
      rd(6'h0C, v); chk(v == 32'hA, "R10 enable", v, 32'hA);
      chk(irq_second, "R11 irq on enable", {31'h0, irq_second}, 32'h1);

      // R9 set beats clear: divider 0 ticks on every enable
      wr(6'h08, 32'h0);
      wr(6'h0C, 32'hA);
      chk(bus_rdata[1] == 1'b1, "R9 set wins", bus_rdata, 32'hA);
      // R8 every tick sets the tick flag
      measure(4, t); chk(t == 4, "R8 tick each enable", t, 4);

      // R2 decode
      wr(6'h10, 32'hDEAD_BEEF);
      rd(6'h10, v); chk(v == 32'h0, "R2 unused read", v, 32'h0);
      rd(6'h3C, v); chk(v == 32'h0, "R2 unused high", v, 32'h0);
      rd(6'h01, v); chk(v == 32'd3, "R2 low bits ignored", v, 32'd3);
      rd(6'h09, v); chk(v == 32'h0, "R2 low bits prescaler", v, 32'h0);

      // R4 trim once per 1024 periods
      wr(6'h08, (32'd3 << 16) | 32'd5);
      measure(1024, t); chk(t == 1024 * 6 - 3, "R4 trim", t, 1024 * 6 - 3);
      wr(6'h08, (32'd9 << 16) | 32'd3);
      measure(1024, t); chk(t == 1023 * 4 + 1, "R4 trim saturate", t, 1023 * 4 + 1);

      // random traffic against the model
      osc_rnd = 1'b1;
      wr(6'h0C, 32'hF);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk); #1;
         bus_wr = ($urandom % 3) == 0;
         case ($urandom % 5)
            0: begin bus_addr = 6'h00; bus_wdata = $urandom % 8; end
            1: begin bus_addr = 6'h04; bus_wdata = $urandom % 8; end
            2: begin bus_addr = 6'h08; bus_wdata = (($urandom % 3) << 16) | ($urandom % 4); end
            3: begin bus_addr = 6'h0C; bus_wdata = $urandom % 16; end
            default: begin bus_addr = 6'h14; bus_wdata = $urandom; end
         endcase
      end
      @(negedge clk); #1 bus_wr = 1'b0;
      osc_rnd = 1'b0; osc_on = 1'b0;

      // R1 again after a mid-run reset
      do_reset();
      check_reset_state();

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule